// File: doc/BRIEF.md
# Complementary PWM Generator with Deadtime and Fault Shutdown

This block drives the two switches of one half-bridge leg. A clock-enable prescaler slows the system clock down to counter ticks. An up-counter runs from zero to a period limit and then starts again. A compare threshold splits each period into an active part and an inactive part. From that split the block forms two legs:

- a high-side output, active while the counter is below the threshold;
- a low-side output, active for the rest of the period.

Each leg delays its turn-on by a programmable deadtime, so the two switches never conduct together.

A fault input may change at any time relative to the clock. When it asserts, the output enable drops and both pins go to their resting level. They stay there until software sets the enable again. Configuration arrives through a single-cycle write port. The period limit and the threshold can each be buffered, so that a new value only takes effect at the next counter wrap.

Top module: `cpwm_bridge`

## Requirements
- R1: The counter advances once every PSC+1 clocks, where PSC is the prescale value written at address 1. A full period is therefore (ARR+1)*(PSC+1) clocks.
- R2: The counter counts 0, 1, ..., ARR and then returns to 0 on the tick after it has reached ARR. ARR is written at address 2.
- R3: The reference is active while the counter is below CCR, which is written at address 3. With zero deadtime the high-side output is active for CCR*(PSC+1) clocks in each period, and the low-side output for the remaining clocks.
- R4: When CCR is 0, the high-side output is never active and the low-side output is always active. When CCR is greater than ARR, the reverse holds.
- R5: Control bit 1 (address 0) buffers ARR.
  - With the bit set, a written ARR takes effect only at the next counter wrap.
  - With the bit clear, it takes effect on the following clock.
- R6: Control bit 2 buffers CCR in the same way: with the bit set, a written CCR takes effect at the next wrap; with it clear, on the following clock.
- R7: Control bit 3 selects the polarity of both pins.
  - With the bit at 0, a pin is high when active and low when inactive.
  - With the bit at 1, both levels are inverted.
- R8: With a deadtime of 0, the low-side output is the exact inverse of the high-side output on every clock.
- R9: A nonzero deadtime DT is written at address 4, in its low 8 bits. It delays each leg's turn-on by DT clocks, so each active pulse is shorter by DT. The two outputs are never active together.
- R10: If a leg's wanted pulse is DT clocks long or shorter, that leg stays inactive for the whole pulse.
- R11: When the fault input asserts, the enable output falls within three clocks. The enable then stays low after the fault is released, until control bit 4 is written as 1. A write of that bit while the fault is still present has no effect.
- R12: While the enable is low, both pins sit at their inactive level. Out of reset the enable is low and both pins are low.
- R13: Control bit 0 runs the prescaler and the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one clock |
| wr_addr | input | 3 | Register select: 0 control, 1 prescale, 2 period limit, 3 compare, 4 deadtime |
| wr_data | input | CNT_W (16) | Write data |
| brk_in | input | 1 | Fault input; asynchronous, active high |
| pwm_hi | output | 1 | High-side switch drive |
| pwm_lo | output | 1 | Low-side switch drive |
| out_en | output | 1 | Output enable state: 1 while the pins follow the PWM |

## Verification
The hardest case to create from the ports is a buffered register write that lands in the middle of a period. The bench has to observe that the period in progress still follows the old value. To get there, the bench watches one pin for a falling edge (for the limit) or a rising edge (for the threshold), so it knows the counter sits just past that point. It then writes the new value at once, and measures the interval from that edge to the next one in clocks.

The same write is repeated with buffering off, and the interval then changes in the current period. Random settings of prescale, limit, threshold, deadtime and polarity are checked against pulse widths and periods computed from the requirements. Directed cases cover pulses exactly as long as the deadtime, both extremes of the threshold, and a fault with an enable write attempted while the fault is still held.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    // Register select values on the write port
    typedef enum logic [2:0] {
        A_CTRL = 3'd0,
        A_PSC  = 3'd1,
        A_ARR  = 3'd2,
        A_CCR  = 3'd3,
        A_DT   = 3'd4
    } cpwm_addr_e;

    // Control word, bit 0 is the last member
    typedef struct packed {
        logic outen;    // bit 4
        logic act_low;  // bit 3
        logic ccr_buf;  // bit 2
        logic arr_buf;  // bit 1
        logic run;      // bit 0
    } cpwm_ctrl_t;

    localparam int CTRL_W = $bits(cpwm_ctrl_t);

    function automatic cpwm_ctrl_t ctrl_decode(input logic [CTRL_W-1:0] raw);
        return cpwm_ctrl_t'(raw);
    endfunction

    // Pin level from leg activity, enable and polarity
    function automatic logic drive_pin(input logic act, input logic en, input logic act_low);
        return act_low ^ (en & act);
    endfunction

endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         arr_buf,
    input  logic         ccr_buf,
    input  logic [W-1:0] psc,
    input  logic [W-1:0] arr_new,
    input  logic [W-1:0] ccr_new,
    output logic [W-1:0] cnt,
    output logic [W-1:0] arr_act,
    output logic [W-1:0] ccr_act,
    output logic         tick,
    output logic         wrap,
    output logic         ref_act
);

    logic [W-1:0] div;

    // Compare with >= so a shrunken limit never strands the counter
    assign tick = run && (div >= psc);
    assign wrap = tick && (cnt >= arr_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            div     <= '0;
            cnt     <= '0;
            arr_act <= '1;
            ccr_act <= '0;
            ref_act <= 1'b0;
        end else begin
            if (run) begin
                div <= tick ? '0 : div + 1'b1;
            end
            if (tick) begin
                cnt <= wrap ? '0 : cnt + 1'b1;
            end
            if (!arr_buf || wrap) begin
                arr_act <= arr_new;
            end
            if (!ccr_buf || wrap) begin
                ccr_act <= ccr_new;
            end
            ref_act <= (cnt < ccr_act);
        end
    end

endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DT_W-1:0] dt,
    input  logic            want,
    output logic            act
);

    logic [DT_W-1:0] hold;

    // Turn-on waits dt clocks; turn-off follows want at once
    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
            act  <= 1'b0;
        end else if (!want) begin
            hold <= '0;
            act  <= 1'b0;
        end else if (hold >= dt) begin
            act <= 1'b1;
        end else begin
            hold <= hold + 1'b1;
        end
    end

endmodule

// File: rtl/cpwm_guard.sv
module cpwm_guard #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic brk_raw,
    input  logic en_set,
    input  logic en_clr,
    output logic en,
    output logic brk_seen
);

    logic [SYNC_N-1:0] sync;

    assign brk_seen = sync[SYNC_N-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync <= '0;
            en   <= 1'b0;
        end else begin
            sync <= {sync[SYNC_N-2:0], brk_raw};
            if (brk_seen) begin
                en <= 1'b0;
            end else if (en_set) begin
                en <= 1'b1;
            end else if (en_clr) begin
                en <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cpwm_bridge.sv
module cpwm_bridge
    import cpwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DT_W   = 8,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             brk_in,
    output logic             pwm_hi,
    output logic             pwm_lo,
    output logic             out_en
);

    localparam int LEGS = 2;

    cpwm_ctrl_t      wr_ctrl;
    logic            ctrl_hit;
    logic            run_q, arrb_q, ccrb_q, pol_q;
    logic [CNT_W-1:0] psc_q, arr_sh, ccr_sh;
    logic [DT_W-1:0]  dt_q;

    assign wr_ctrl  = ctrl_decode(wr_data[CTRL_W-1:0]);
    assign ctrl_hit = wr_en && (wr_addr == A_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            arrb_q <= 1'b0;
            ccrb_q <= 1'b0;
            pol_q  <= 1'b0;
            psc_q  <= '0;
            arr_sh <= '1;
            ccr_sh <= '0;
            dt_q   <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    run_q  <= wr_ctrl.run;
                    arrb_q <= wr_ctrl.arr_buf;
                    ccrb_q <= wr_ctrl.ccr_buf;
                    pol_q  <= wr_ctrl.act_low;
                end
                A_PSC:   psc_q  <= wr_data;
                A_ARR:   arr_sh <= wr_data;
                A_CCR:   ccr_sh <= wr_data;
                A_DT:    dt_q   <= wr_data[DT_W-1:0];
                default: ;
            endcase
        end
    end

    logic [CNT_W-1:0] cnt, arr_act, ccr_act;
    logic             tick, wrap, ref_act;

    cpwm_timebase #(.W(CNT_W)) u_tb (
        .clk     (clk),
        .rst     (rst),
        .run     (run_q),
        .arr_buf (arrb_q),
        .ccr_buf (ccrb_q),
        .psc     (psc_q),
        .arr_new (arr_sh),
        .ccr_new (ccr_sh),
        .cnt     (cnt),
        .arr_act (arr_act),
        .ccr_act (ccr_act),
        .tick    (tick),
        .wrap    (wrap),
        .ref_act (ref_act)
    );

    // Leg 0 follows the reference, leg 1 its complement
    logic [LEGS-1:0] want, leg_act;
    assign want = {~ref_act, ref_act};

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        cpwm_deadband #(.DT_W(DT_W)) u_db (
            .clk  (clk),
            .rst  (rst),
            .dt   (dt_q),
            .want (want[g]),
            .act  (leg_act[g])
        );
    end

    logic en_w, brk_seen;

    cpwm_guard #(.SYNC_N(SYNC_N)) u_guard (
        .clk      (clk),
        .rst      (rst),
        .brk_raw  (brk_in),
        .en_set   (ctrl_hit && wr_ctrl.outen),
        .en_clr   (ctrl_hit && !wr_ctrl.outen),
        .en       (en_w),
        .brk_seen (brk_seen)
    );

    assign out_en = en_w;
    assign pwm_hi = drive_pin(leg_act[0], en_w, pol_q);
    assign pwm_lo = drive_pin(leg_act[1], en_w, pol_q);

endmodule

// File: rtl/cpwm_bridge_chk.sv
module cpwm_bridge_chk #(
    parameter int W    = 16,
    parameter int DT_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            hi_act,
    input logic            lo_act,
    input logic            brk_seen,
    input logic            out_en,
    input logic            wrap,
    input logic            arr_buf,
    input logic [W-1:0]    cnt,
    input logic [W-1:0]    arr_act,
    input logic [DT_W-1:0] dt
);

    // R9
    bridge_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(hi_act && lo_act));

    // R11
    bridge_break_chk: assert property (@(posedge clk) disable iff (rst)
        brk_seen |=> !out_en);

    // R2
    bridge_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt == '0));

    // R5
    bridge_arr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (arr_buf && !wrap) |=> $stable(arr_act));

    // R8
    bridge_inverse_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && dt == '0 && $past(dt) == '0) |-> (hi_act != lo_act));

endmodule

bind cpwm_bridge cpwm_bridge_chk #(.W(CNT_W), .DT_W(DT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .hi_act   (leg_act[0]),
    .lo_act   (leg_act[1]),
    .brk_seen (brk_seen),
    .out_en   (out_en),
    .wrap     (wrap),
    .arr_buf  (arrb_q),
    .cnt      (cnt),
    .arr_act  (arr_act),
    .dt       (dt_q)
);

// File: tb/cpwm_bridge_test.sv
module cpwm_bridge_test;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         brk_in = 1'b0;
    logic         pwm_hi, pwm_lo, out_en;

    cpwm_bridge uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .brk_in(brk_in), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .out_en(out_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int overlaps = 0;
    bit pol_b = 1'b0;
    bit done = 1'b0;

    always @(posedge clk) cyc++;

    function automatic bit act(input bit leg);
        return (leg ? pwm_lo : pwm_hi) ^ pol_b;
    endfunction

    // R9 monitor: both legs never active together while enabled
    always @(negedge clk) begin
        if (!rst && out_en && act(0) && act(1)) overlaps++;
    end

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R13 control word: bit0 run, bit1 ARR buffer, bit2 CCR buffer, bit3 polarity, bit4 enable
    task automatic set_ctrl(input bit run, input bit ab, input bit cb, input bit pol, input bit en);
        wr(3'd0, {27'd0, en, pol, cb, ab, run});
    endtask

    task automatic cfg(input int p, input int a, input int c, input int d, input bit pol,
                       input bit ab, input bit cb);
        set_ctrl(1'b0, 1'b0, 1'b0, pol, 1'b0);
        pol_b = pol;
        wr(3'd1, p); wr(3'd2, a); wr(3'd3, c); wr(3'd4, d);
        set_ctrl(1'b1, ab, cb, pol, 1'b1);
        repeat (2 * (a + 1) * (p + 1) + d + 8) @(negedge clk);
    endtask

    task automatic edge_at(input bit leg, input bit lvl, output int t);
        while (act(leg) == lvl) @(negedge clk);
        do @(negedge clk); while (act(leg) != lvl);
        t = cyc;
    endtask

    task automatic const_check(input string req, input bit leg, input bit lvl, input int n);
        int bad = 0;
        repeat (n) begin
            @(negedge clk);
            if (act(leg) != lvl) bad++;
        end
        chk(req, bad, 0);
    endtask

    // Expected active width of a leg: -2 always active, 0 never active
    function automatic int exp_w(input bit leg, input int p, input int a, input int c, input int d);
        int seg;
        if (!leg) begin
            if (c == 0) return 0;
            if (c > a)  return -2;
            seg = c * (p + 1);
        end else begin
            if (c > a)  return 0;
            if (c == 0) return -2;
            seg = (a + 1 - c) * (p + 1);
        end
        return (seg > d) ? seg - d : 0;
    endfunction

    task automatic run_case(input int p, input int a, input int c, input int d, input bit pol);
        int per, w, t1, t2, t3;
        cfg(p, a, c, d, pol, 1'b0, 1'b0);
        per = (a + 1) * (p + 1);
        for (int leg = 0; leg < 2; leg++) begin
            w = exp_w(leg[0], p, a, c, d);
            if (w == -2) begin
                const_check("R4 leg always active", leg[0], 1'b1, per + 4);
            end else if (w == 0) begin
                const_check((c == 0 || c > a) ? "R4 leg never active" : "R10 short pulse suppressed",
                            leg[0], 1'b0, per + d + 4);
            end else begin
                edge_at(leg[0], 1'b1, t1);
                edge_at(leg[0], 1'b0, t2);
                edge_at(leg[0], 1'b1, t3);
                chk((d == 0) ? "R3 R7 active width" : "R9 width minus deadtime", t2 - t1, w);
                chk("R1 R2 period", t3 - t1, per);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int t1, t2, t3, t4, bad;
        void'($urandom(32'd2718));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk("R12 reset enable", out_en, 0);
        chk("R12 reset high pin", pwm_hi, 0);
        chk("R12 reset low pin", pwm_lo, 0);

        // R3 R8 basic waveform and exact inverse
        run_case(0, 9, 4, 0, 1'b0);
        bad = 0;
        repeat (40) begin
            @(negedge clk);
            if (act(0) == act(1)) bad++;
        end
        chk("R8 exact inverse at zero deadtime", bad, 0);

        run_case(1, 7, 3, 2, 1'b0);    // R9 with prescale
        run_case(0, 9, 0, 0, 1'b1);    // R4 CCR zero, R7 active low
        run_case(0, 9, 12, 3, 1'b0);   // R4 CCR above ARR
        run_case(0, 9, 2, 2, 1'b0);    // R10 pulse equals deadtime
        run_case(2, 5, 1, 3, 1'b1);    // R10 prescaled pulse equals deadtime

        // R5 buffered ARR: current period keeps old limit
        cfg(0, 19, 5, 0, 1'b0, 1'b1, 1'b0);
        edge_at(0, 1'b0, t1);
        wr(3'd2, 39);
        edge_at(0, 1'b1, t2);
        chk("R5 buffered ARR keeps period", t2 - t1, 15);
        edge_at(0, 1'b1, t3);
        chk("R5 buffered ARR after wrap", t3 - t2, 40);

        // R5 unbuffered ARR: current period changes
        cfg(0, 19, 5, 0, 1'b0, 1'b0, 1'b0);
        edge_at(0, 1'b0, t1);
        wr(3'd2, 39);
        edge_at(0, 1'b1, t2);
        chk("R5 direct ARR", t2 - t1, 35);

        // R6 buffered CCR: pulse in progress keeps old threshold
        cfg(0, 19, 5, 0, 1'b0, 1'b0, 1'b1);
        edge_at(0, 1'b1, t1);
        wr(3'd3, 12);
        edge_at(0, 1'b0, t2);
        chk("R6 buffered CCR keeps pulse", t2 - t1, 5);
        edge_at(0, 1'b1, t3);
        edge_at(0, 1'b0, t4);
        chk("R6 buffered CCR after wrap", t4 - t3, 12);

        // R6 unbuffered CCR: pulse in progress changes
        set_ctrl(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        edge_at(0, 1'b1, t1);
        wr(3'd3, 8);
        edge_at(0, 1'b0, t2);
        chk("R6 direct CCR", t2 - t1, 8);

        // R11 fault shutdown
        cfg(0, 9, 4, 0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        brk_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 enable drops within three clocks", out_en, 0);
        chk("R12 R7 high pin inactive level", pwm_hi, 1);
        chk("R12 R7 low pin inactive level", pwm_lo, 1);
        set_ctrl(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        repeat (2) @(negedge clk);
        chk("R11 enable write ignored during fault", out_en, 0);
        brk_in = 1'b0;
        bad = 0;
        repeat (12) begin
            @(negedge clk);
            if (out_en || !pwm_hi || !pwm_lo) bad++;
        end
        chk("R11 stays off after release", bad, 0);
        set_ctrl(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        chk("R11 enable restored by write", out_en, 1);
        edge_at(0, 1'b1, t1);
        edge_at(0, 1'b0, t2);
        chk("R11 R3 waveform resumes", t2 - t1, 4);

        // Random mix
        for (int i = 0; i < 16; i++) begin
            int p, a, c, d;
            p = $urandom_range(0, 2);
            a = $urandom_range(2, 30);
            c = $urandom_range(0, a + 2);
            d = $urandom_range(0, 12);
            run_case(p, a, c, d, $urandom_range(0, 1) != 0);
        end

        chk("R9 no overlap of active legs", overlaps, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule